// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Unit

This unit resolves the interrupt entry of an 8-bit processor core when the core uses table-driven dispatch. Two asynchronous request inputs, both active low, are first synchronised. One is maskable and the other is not. The unit then decides which request to serve and produces the 16-bit entry address that the program counter loads. The core drives the outputs that set and clear the enable flag. The value of the core's interrupt page register is applied to `page_byte`.

When it accepts a maskable request, the unit raises two acknowledge strobes. The first marks an instruction-fetch slot and the second marks an I/O request. While both strobes are high, the requesting device places one byte on `data_in`. The unit forms a table pointer from two bytes: the page byte is the upper half and the device byte is the lower half. It reads the entry address from that table location in two single-byte memory reads, using a request/ready handshake. A non-maskable request takes priority. It bypasses the table and goes straight to a fixed entry address.

Top module: `vec_irq_ack`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `tgt_vld`, `mem_rd`, `ack_fetch`, `ack_io` and `ie_flag` are all 0. The bench holds `rst` for four clock cycles.
- R2: A low level on `maskreq_n` has no effect while `ie_flag` is 0. No strobe is raised, no memory read is issued and no `tgt_vld` is produced.
- R3: Accepting a maskable request clears `ie_flag` on the same edge that raises the strobes. If `ie_set` arrives in the same cycle, acceptance still wins.
- R4: On acceptance, `ack_fetch` and `ack_io` are both high for exactly ACK_CYC cycles (default 2). The byte on `data_in` in the last of those cycles is taken as the table pointer's low byte. `mem_rd` is never high while the strobes are high.
- R5: The table pointer is {`page_byte`, device byte}. The first read is issued at the pointer and the second at pointer+1, computed modulo 65536, so 16'hFFFF is followed by 16'h0000.
- R6: `tgt_addr` = {second byte read, first byte read}, presented with a `tgt_vld` pulse that lasts exactly one cycle.
- R7: `mem_rd` stays high and `mem_addr` stays unchanged until a cycle in which `mem_rdy` is 1. That cycle completes the read and `data_in` supplies the byte.
- R8: Each falling edge on `urgreq_n` produces exactly one `tgt_vld`, with `tgt_addr` = NMI_ADDR (default 16'h0040). This holds however long the input stays low. No strobe and no memory read take place.
- R9: When both requests become active in the same cycle, the non-maskable service is delivered before the maskable one.
- R10: A pulse on `ie_set` sets `ie_flag` and a pulse on `ie_clr` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| maskreq_n | input | 1 | Maskable request, active low, level, asynchronous |
| urgreq_n | input | 1 | Non-maskable request, active low, falling edge, asynchronous |
| ie_set | input | 1 | Sets the enable flag |
| ie_clr | input | 1 | Clears the enable flag |
| ie_flag | output | 1 | Maskable-request enable flag |
| page_byte | input | 8 | Interrupt page register value (pointer high byte) |
| data_in | input | 8 | Shared data bus: device byte, then table bytes |
| ack_fetch | output | 1 | Acknowledge strobe, fetch-slot marker |
| ack_io | output | 1 | Acknowledge strobe, I/O request |
| mem_rd | output | 1 | Memory read request |
| mem_rdy | input | 1 | Memory read ready |
| mem_addr | output | 16 | Memory read address |
| tgt_addr | output | 16 | Service entry address |
| tgt_vld | output | 1 | One-cycle pulse, `tgt_addr` valid |

## Verification
The assertions take the environment for granted in three ways. They assume that `mem_rdy` is raised only while `mem_rd` is high. They assume that the device drives `data_in` only while both acknowledge strobes are high. They assume that a request level is held for longer than the synchroniser depth, so that every edge reaches the control logic. The bench keeps within these limits. It uses a single responder that answers at the falling clock edge. That responder gives the vector byte only while the strobes are high and gives table bytes only while `mem_rd` is high. It inserts a programmable number of wait cycles before ready. Each request is held for at least tens of cycles, or until the strobes appear.

// File: rtl/via_pkg.sv
package via_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_RLO  = 2'd2,
    ST_RHI  = 2'd3
  } via_state_t;
endpackage

// File: rtl/via_sync.sv
module via_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/via_edge_latch.sv
module via_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic lvl_n,
  input  logic take,
  output logic pend
);
  logic prev_q;
  logic pend_q;
  logic fall;

  assign fall = prev_q & ~lvl_n;
  assign pend = pend_q | fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_n;
      pend_q <= pend & ~take;
    end
  end
endmodule

// File: rtl/via_enable.sv
module via_enable (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic accept_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)           flag_o <= 1'b0;
    else if (accept_i) flag_o <= 1'b0;
    else if (clr_i)    flag_o <= 1'b0;
    else if (set_i)    flag_o <= 1'b1;
  end
endmodule

// File: rtl/via_seq.sv
module via_seq
  import via_pkg::*;
#(
  parameter int DW = 8,
  parameter int ACK_CYC = 2,
  parameter logic [2*DW-1:0] NMI_ADDR = 16'h0040
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mreq_act,
  input  logic            ie,
  input  logic            nmi_pend,
  input  logic [DW-1:0]   page,
  input  logic [DW-1:0]   din,
  input  logic            mem_rdy,
  output logic            accept,
  output logic            nmi_take,
  output logic            ack_fetch,
  output logic            ack_io,
  output logic            mem_rd,
  output logic [2*DW-1:0] mem_addr,
  output logic [2*DW-1:0] tgt,
  output logic            tgt_vld
);
  localparam int AW = 2 * DW;
  localparam int CW = $clog2(ACK_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(ACK_CYC - 1);

  via_state_t    st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] lo_q;

  assign nmi_take = (st == ST_IDLE) && nmi_pend;
  assign accept   = (st == ST_IDLE) && !nmi_pend && mreq_act && ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      lo_q      <= '0;
      ack_fetch <= 1'b0;
      ack_io    <= 1'b0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
      tgt       <= '0;
      tgt_vld   <= 1'b0;
    end else begin
      tgt_vld <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (nmi_take) begin
            tgt     <= NMI_ADDR;
            tgt_vld <= 1'b1;
          end else if (accept) begin
            st        <= ST_ACK;
            cnt       <= '0;
            ack_fetch <= 1'b1;
            ack_io    <= 1'b1;
          end
        end
        ST_ACK: begin
          if (cnt == CNT_LAST) begin
            ack_fetch <= 1'b0;
            ack_io    <= 1'b0;
            mem_rd    <= 1'b1;
            mem_addr  <= {page, din};
            st        <= ST_RLO;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RLO: begin
          if (mem_rdy) begin
            lo_q     <= din;
            mem_addr <= mem_addr + AW'(1);
            st       <= ST_RHI;
          end
        end
        ST_RHI: begin
          if (mem_rdy) begin
            mem_rd  <= 1'b0;
            tgt     <= {din, lo_q};
            tgt_vld <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vec_irq_ack.sv
module vec_irq_ack #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ACK_CYC = 2,
  parameter logic [2*DW-1:0] NMI_ADDR = 16'h0040
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            maskreq_n,
  input  logic            urgreq_n,
  input  logic            ie_set,
  input  logic            ie_clr,
  output logic            ie_flag,
  input  logic [DW-1:0]   page_byte,
  input  logic [DW-1:0]   data_in,
  output logic            ack_fetch,
  output logic            ack_io,
  output logic            mem_rd,
  input  logic            mem_rdy,
  output logic [2*DW-1:0] mem_addr,
  output logic [2*DW-1:0] tgt_addr,
  output logic            tgt_vld
);
  logic [1:0] req_s;
  logic       nmi_pend;
  logic       nmi_take;
  logic       accept;

  via_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({urgreq_n, maskreq_n}),
    .q   (req_s)
  );

  via_edge_latch u_nmi (
    .clk   (clk),
    .rst   (rst),
    .lvl_n (req_s[1]),
    .take  (nmi_take),
    .pend  (nmi_pend)
  );

  via_enable u_ie (
    .clk      (clk),
    .rst      (rst),
    .set_i    (ie_set),
    .clr_i    (ie_clr),
    .accept_i (accept),
    .flag_o   (ie_flag)
  );

  via_seq #(.DW(DW), .ACK_CYC(ACK_CYC), .NMI_ADDR(NMI_ADDR)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .mreq_act  (~req_s[0]),
    .ie        (ie_flag),
    .nmi_pend  (nmi_pend),
    .page      (page_byte),
    .din       (data_in),
    .mem_rdy   (mem_rdy),
    .accept    (accept),
    .nmi_take  (nmi_take),
    .ack_fetch (ack_fetch),
    .ack_io    (ack_io),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .tgt       (tgt_addr),
    .tgt_vld   (tgt_vld)
  );
endmodule

// File: rtl/vec_irq_ack_chk.sv
module vec_irq_ack_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] NMI_ADDR = 16'h0040
) (
  input logic          clk,
  input logic          rst,
  input logic          ie_flag,
  input logic          ack_fetch,
  input logic          ack_io,
  input logic          mem_rd,
  input logic          mem_rdy,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] tgt_addr,
  input logic          tgt_vld
);
  logic lo_phase;

  always_ff @(posedge clk) begin
    if (rst)                    lo_phase <= 1'b0;
    else if (ack_fetch)         lo_phase <= 1'b1;
    else if (mem_rd && mem_rdy) lo_phase <= 1'b0;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!tgt_vld && !mem_rd && !ack_fetch && !ack_io && !ie_flag));

  a_r2_accept_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_fetch) |-> $past(ie_flag));

  a_r3_enable_cleared: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_fetch) |-> !ie_flag);

  a_r4_no_bus_overlap: assert property (@(posedge clk) disable iff (rst)
    !((ack_fetch || ack_io) && mem_rd));

  a_r5_second_read_next: assert property (@(posedge clk) disable iff (rst)
    (lo_phase && mem_rd && mem_rdy) |=> (mem_rd && mem_addr == $past(mem_addr) + 16'd1));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tgt_vld |=> !tgt_vld);

  a_r7_read_held: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr)));

  a_r8_direct_entry: assert property (@(posedge clk) disable iff (rst)
    (tgt_vld && !$past(mem_rd)) |-> (tgt_addr == NMI_ADDR));
endmodule

bind vec_irq_ack vec_irq_ack_chk #(.AW(2*DW), .NMI_ADDR(NMI_ADDR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ie_flag   (ie_flag),
  .ack_fetch (ack_fetch),
  .ack_io    (ack_io),
  .mem_rd    (mem_rd),
  .mem_rdy   (mem_rdy),
  .mem_addr  (mem_addr),
  .tgt_addr  (tgt_addr),
  .tgt_vld   (tgt_vld)
);

// File: tb/vec_irq_ack_tb.sv
module vec_irq_ack_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ACK_CYC = 2;
  localparam logic [15:0] NMI_ADDR = 16'h0040;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        maskreq_n = 1'b1;
  logic        urgreq_n = 1'b1;
  logic        ie_set = 1'b0;
  logic        ie_clr = 1'b0;
  logic        ie_flag;
  logic [7:0]  page_byte = 8'h00;
  logic [7:0]  data_in = 8'h00;
  logic        ack_fetch, ack_io, mem_rd, tgt_vld;
  logic        mem_rdy = 1'b0;
  logic [15:0] mem_addr, tgt_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  vec_byte = 8'h00;
  int          rdy_delay = 0;
  int          wcnt = 0;
  logic [15:0] alog [4];
  int          acount = 0;

  vec_irq_ack #(.ACK_CYC(ACK_CYC), .NMI_ADDR(NMI_ADDR)) u_dut (
    .clk(clk), .rst(rst), .maskreq_n(maskreq_n), .urgreq_n(urgreq_n),
    .ie_set(ie_set), .ie_clr(ie_clr), .ie_flag(ie_flag),
    .page_byte(page_byte), .data_in(data_in),
    .ack_fetch(ack_fetch), .ack_io(ack_io),
    .mem_rd(mem_rd), .mem_rdy(mem_rdy), .mem_addr(mem_addr),
    .tgt_addr(tgt_addr), .tgt_vld(tgt_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] tbl(input logic [15:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd3;
    return m ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus responder: vector byte during strobes, table bytes during reads
  initial begin
    forever begin
      @(negedge clk);
      mem_rdy = 1'b0;
      data_in = 8'h00;
      if (ack_fetch && ack_io) begin
        data_in = vec_byte;
        wcnt = 0;
      end else if (mem_rd) begin
        if (wcnt >= rdy_delay) begin
          mem_rdy = 1'b1;
          data_in = tbl(mem_addr);
          if (acount < 4) alog[acount] = mem_addr;
          acount++;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end else begin
        wcnt = 0;
      end
    end
  end

  task automatic pulse_ie(input bit set);
    @(negedge clk);
    if (set) ie_set = 1'b1; else ie_clr = 1'b1;
    @(negedge clk);
    ie_set = 1'b0;
    ie_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk(!tgt_vld && !mem_rd && !ack_fetch && !ack_io && !ie_flag, "R1",
        "outputs after reset",
        {27'd0, tgt_vld, mem_rd, ack_fetch, ack_io, ie_flag}, 32'd0);
  endtask

  task automatic t_enable_ctrl;
    pulse_ie(1'b1);
    chk(ie_flag == 1'b1, "R10", "flag after set", ie_flag, 1);
    pulse_ie(1'b0);
    chk(ie_flag == 1'b0, "R10", "flag after clear", ie_flag, 0);
  endtask

  task automatic t_masked_ignored;
    int acks = 0;
    int vlds = 0;
    acount = 0;
    @(negedge clk);
    maskreq_n = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ack_fetch || ack_io) acks++;
      if (tgt_vld) vlds++;
    end
    maskreq_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(acks == 0, "R2", "strobes while disabled", acks, 0);
    chk(vlds == 0 && acount == 0, "R2", "service while disabled", vlds + acount, 0);
  endtask

  task automatic t_vector(input logic [7:0] pg, input logic [7:0] vb, input int dly,
                          input bit ie_race);
    int acks = 0;
    int vlds = 0;
    int vwidth = 0;
    logic [15:0] got = 16'h0;
    logic [15:0] ptr;
    logic [15:0] ptr2;
    logic [15:0] exp_t;
    ptr = {pg, vb};
    ptr2 = ptr + 16'd1;
    exp_t = {tbl(ptr2), tbl(ptr)};
    pulse_ie(1'b1);
    page_byte = pg;
    vec_byte = vb;
    rdy_delay = dly;
    acount = 0;
    @(negedge clk);
    maskreq_n = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ack_fetch && ack_io) begin
        acks++;
        maskreq_n = 1'b1;
      end
      if (ie_race) ie_set = (i == 1);
      if (tgt_vld) begin
        vlds++;
        got = tgt_addr;
        vwidth++;
      end
    end
    ie_set = 1'b0;
    maskreq_n = 1'b1;
    chk(acks == ACK_CYC, "R4", "strobe cycles", acks, ACK_CYC);
    chk(alog[0] == ptr, "R5", "first read address", alog[0], ptr);
    chk(alog[1] == ptr2, "R5", "second read address", alog[1], ptr2);
    chk(acount == 2, "R7", "read count", acount, 2);
    chk(vlds == 1, "R6", "valid pulses", vlds, 1);
    chk(got == exp_t, "R6", "target", got, exp_t);
    chk(ie_flag == 1'b0, "R3", "flag after acceptance", ie_flag, 0);
  endtask

  task automatic t_nmi;
    int acks = 0;
    int vlds = 0;
    logic [15:0] got = 16'h0;
    acount = 0;
    @(negedge clk);
    urgreq_n = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ack_fetch || ack_io) acks++;
      if (tgt_vld) begin vlds++; got = tgt_addr; end
    end
    urgreq_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(vlds == 1, "R8", "services per edge", vlds, 1);
    chk(got == NMI_ADDR, "R8", "fixed target", got, NMI_ADDR);
    chk(acks == 0 && acount == 0, "R8", "no table access", acks + acount, 0);
  endtask

  task automatic t_priority;
    int vlds = 0;
    logic [15:0] first = 16'h0;
    logic [15:0] second = 16'h0;
    logic [15:0] exp_t;
    exp_t = {tbl(16'h2211), tbl(16'h2210)};
    pulse_ie(1'b1);
    page_byte = 8'h22;
    vec_byte = 8'h10;
    rdy_delay = 1;
    acount = 0;
    @(negedge clk);
    maskreq_n = 1'b0;
    urgreq_n = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ack_fetch && ack_io) maskreq_n = 1'b1;
      if (tgt_vld) begin
        if (vlds == 0) first = tgt_addr; else second = tgt_addr;
        vlds++;
      end
    end
    maskreq_n = 1'b1;
    urgreq_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(vlds == 2, "R9", "services for both", vlds, 2);
    chk(first == NMI_ADDR, "R9", "first service", first, NMI_ADDR);
    chk(second == exp_t, "R9", "second service", second, exp_t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable_ctrl();
    t_masked_ignored();
    t_vector(8'h12, 8'h34, 0, 1'b0);
    t_vector(8'hA0, 8'h7E, 3, 1'b1);   // R3 race: set pulse during acceptance window
    t_vector(8'hFF, 8'hFF, 1, 1'b0);   // R5 wrap to 0000
    t_nmi();
    t_priority();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule